// File: doc/BRIEF.md
# Triggered Debug-Bus Capture Engine

This block records a 64-bit sample stream into an external circular sample memory. Recording continues until a chosen trigger event occurs and a programmed post-trigger delay has elapsed. Software sets the enable, the trigger configuration, the delay and the sample rate. It then pulses the arm input and polls the busy flag, which the hardware drops when the capture is complete.

The trigger comes from one bit of a 32-bit trigger bus, picked by a 5-bit index, and fires on its rising or falling edge. In manual mode it fires instead on a 0-to-1 change of a dedicated request bit. The post-trigger delay is a 7-bit count times a power-of-two number of microseconds. A microsecond tick is derived from the parameter `CLK_MHZ`.

The capture clock runs at twice the nominal base sample rate. A 3-bit rate code picks how often a sample is taken. When capture completes, the block latches a status word. That word holds a wrap flag and the memory address of the last sample written, so the host can read the ring back in time order.

Top module: `lac_capture`

## Requirements
- R1: After reset `busy`, `done` and `mem_we` are 0 and `status` is 0.
- R2: A cycle with `arm_set`=1, `cfg_en`=1 and `busy`=0 sets `busy` on the next clock edge; `arm_set` is ignored while `cfg_en`=0.
- R3: While busy, a sample of `smp_data` is written every D cycles. D is 1 for `rate_code`=7 and 2^(code+1) for codes 0..6. The first write lands one cycle after `busy` rises. Addresses run 0,1,2,… modulo 2^`ADDR_W`, and `mem_wdata` is the `smp_data` value sampled at the write edge.
- R4: With `trig_mode`=0 the trigger source is `trig_bus[trig_sel]`. Other bus bits, and any transition that happens while not busy, have no effect.
- R5: `trig_edge`=0 fires on a 0-to-1 transition of the source and `trig_edge`=1 on a 1-to-0 transition; the opposite transition does not fire.
- R6: With `trig_mode`=1 the trigger fires on a 0-to-1 transition of `man_trig`, whatever `trig_edge` and `trig_bus` hold.
- R7: Let E be the clock edge at which a trigger is accepted. `done` pulses for exactly one cycle at edge E+1+`dly_cnt`·2^u·`CLK_MHZ`, where u is `dly_unit`, with values above 6 treated as 6.
- R8: `busy` falls on the same edge as `done`. No write occurs on that edge or afterwards until re-arm, and `mem_we` is never 1 while `busy` is 0.
- R9: On completion `status` becomes {wrap, last address zero-extended to 15 bits, 16'h0}. The wrap flag is 1 if address 2^`ADDR_W`−1 was written during this capture. `status` changes only on a `done` edge.
- R10: Dropping `cfg_en` while busy clears `busy` on the next edge, with no `done` pulse and no change to `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock (2× nominal base sample rate) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Capture hardware enable |
| arm_set | input | 1 | Pulse to start a capture |
| trig_mode | input | 1 | 0: trigger bus bit, 1: manual request bit |
| trig_edge | input | 1 | 0: rising, 1: falling |
| trig_sel | input | 5 | Trigger bus bit index |
| man_trig | input | 1 | Manual trigger request bit |
| dly_cnt | input | 7 | Post-trigger delay count |
| dly_unit | input | 3 | Delay unit exponent (2^u µs) |
| rate_code | input | 3 | Sample rate code |
| trig_bus | input | 32 | Trigger source bus |
| smp_data | input | 64 | Sample stream |
| mem_we | output | 1 | Sample memory write enable |
| mem_addr | output | ADDR_W | Sample memory write address |
| mem_wdata | output | 64 | Sample memory write data |
| busy | output | 1 | Capture in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 32 | {wrap, finish address, 16'h0} |

## Verification
Each result has a fixed due cycle. `busy` follows an arm one edge later. The first write appears one edge after that, and later writes follow every D edges. `done`, the fall of `busy` and the new `status` all appear together at trigger edge + 1 + delay cycles. The bench drives stimulus on falling edges and counts rising edges from the drive point. It checks that `done` appears at exactly that count. It predicts the write count and the last address from the arm and trigger edge numbers, and it samples all outputs on falling edges so that nothing depends on ordering at the active edge.

// File: rtl/lac_pkg.sv
package lac_pkg;
  localparam int RATE_W = 3;
  localparam int DIV_W  = 8;
  localparam int DLY_W  = 13;

  // cycles between samples for a rate code
  function automatic logic [DIV_W-1:0] rate_div(input logic [RATE_W-1:0] code);
    if (code == 3'd7) return DIV_W'(1);
    return DIV_W'(2 << code);
  endfunction
endpackage

// File: rtl/lac_rate_gen.sv
module lac_rate_gen
  import lac_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [RATE_W-1:0] code,
  output logic              strobe
);
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_len;

  assign div_len = rate_div(code);
  assign strobe  = run && (div_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !run)                  div_cnt <= '0;
    else if (div_cnt == div_len - 1'b1) div_cnt <= '0;
    else                              div_cnt <= div_cnt + 1'b1;
  end
endmodule

// File: rtl/lac_trig_det.sv
module lac_trig_det #(
  parameter int BUS_W = 32,
  localparam int SEL_W = $clog2(BUS_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] trig_bus,
  input  logic [SEL_W-1:0] sel,
  input  logic             manual,
  input  logic             man_bit,
  input  logic             fall_edge,
  output logic             hit
);
  logic src, src_q;

  assign src = manual ? man_bit : trig_bus[sel];

  always_ff @(posedge clk) begin
    if (rst) src_q <= 1'b0;
    else     src_q <= src;
  end

  always_comb begin
    if (!manual && fall_edge) hit = src_q && !src;
    else                      hit = src && !src_q;
  end

  // R5
  edge_pol_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !manual) |-> (src_q == fall_edge));
endmodule

// File: rtl/lac_delay_timer.sv
module lac_delay_timer
  import lac_pkg::*;
#(
  parameter int CLK_MHZ = 160,
  localparam int UW = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [6:0] cnt,
  input  logic [2:0] unit,
  output logic       expire
);
  logic [UW-1:0]    us_cnt;
  logic [DLY_W-1:0] elapsed;
  logic [DLY_W-1:0] target;
  logic [2:0]       u_eff;
  logic             tick;

  assign u_eff  = (unit > 3'd6) ? 3'd6 : unit;
  assign target = DLY_W'(cnt) << u_eff;
  assign tick   = (us_cnt == UW'(CLK_MHZ - 1));
  assign expire = run && (elapsed == target);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      us_cnt  <= '0;
      elapsed <= '0;
    end else if (tick) begin
      us_cnt  <= '0;
      elapsed <= elapsed + 1'b1;
    end else begin
      us_cnt  <= us_cnt + 1'b1;
    end
  end

  // R7
  elapsed_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> (elapsed >= $past(elapsed)));
endmodule

// File: rtl/lac_capture.sv
module lac_capture
  import lac_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int SMP_W   = 64,
  parameter int BUS_W   = 32,
  parameter int CLK_MHZ = 160,
  localparam int SEL_W  = $clog2(BUS_W),
  localparam int DEPTH  = 2 ** ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              arm_set,
  input  logic              trig_mode,
  input  logic              trig_edge,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic              man_trig,
  input  logic [6:0]        dly_cnt,
  input  logic [2:0]        dly_unit,
  input  logic [RATE_W-1:0] rate_code,
  input  logic [BUS_W-1:0]  trig_bus,
  input  logic [SMP_W-1:0]  smp_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [SMP_W-1:0]  mem_wdata,
  output logic              busy,
  output logic              done,
  output logic [31:0]       status
);
  logic              strobe, hit, expire, trig_seen, wrap;
  logic [ADDR_W-1:0] wr_ptr, last_addr;
  logic [14:0]       fin_addr;

  assign fin_addr = 15'(last_addr);

  lac_rate_gen u_rate (
    .clk(clk), .rst(rst), .run(busy), .code(rate_code), .strobe(strobe)
  );

  lac_trig_det #(.BUS_W(BUS_W)) u_trig (
    .clk(clk), .rst(rst), .trig_bus(trig_bus), .sel(trig_sel),
    .manual(trig_mode), .man_bit(man_trig), .fall_edge(trig_edge), .hit(hit)
  );

  lac_delay_timer #(.CLK_MHZ(CLK_MHZ)) u_dly (
    .clk(clk), .rst(rst), .run(busy && trig_seen),
    .cnt(dly_cnt), .unit(dly_unit), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      trig_seen <= 1'b0;
      wrap      <= 1'b0;
      wr_ptr    <= '0;
      last_addr <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      status    <= '0;
    end else begin
      mem_we <= 1'b0;
      done   <= 1'b0;
      if (!busy) begin
        if (arm_set && cfg_en) begin
          busy      <= 1'b1;
          trig_seen <= 1'b0;
          wrap      <= 1'b0;
          wr_ptr    <= '0;
          last_addr <= '0;
        end
      end else if (!cfg_en) begin
        busy <= 1'b0;
      end else if (expire) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        status <= {wrap, fin_addr, 16'h0000};
      end else begin
        if (hit && !trig_seen) trig_seen <= 1'b1;
        if (strobe) begin
          mem_we    <= 1'b1;
          mem_addr  <= wr_ptr;
          mem_wdata <= smp_data;
          last_addr <= wr_ptr;
          wr_ptr    <= wr_ptr + 1'b1;
          if (wr_ptr == ADDR_W'(DEPTH - 1)) wrap <= 1'b1;
        end
      end
    end
  end

  // R2
  arm_start_chk: assert property (@(posedge clk) disable iff (rst)
    (arm_set && cfg_en && !busy) |=> busy);
  // R4
  trig_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_seen) |-> busy);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R8
  write_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(status) |-> done);
  // R10
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !cfg_en) |=> (!busy && !done));
endmodule

// File: tb/sim_lac_capture.sv
module sim_lac_capture;
  localparam int AW  = 4;
  localparam int DEP = 16;
  localparam int MHZ = 3;
  localparam int NV  = 7;
  // fields: mode, edge, sel[5], cnt[7], unit[3], rate[3], pre[8]
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 1'b0, 5'd3,  7'd0,   3'd0, 3'd7, 8'd5},
    {1'b0, 1'b1, 5'd17, 7'd4,   3'd0, 3'd0, 8'd10},
    {1'b0, 1'b0, 5'd31, 7'd10,  3'd2, 3'd1, 8'd20},
    {1'b1, 1'b1, 5'd2,  7'd3,   3'd1, 3'd7, 8'd2},
    {1'b0, 1'b0, 5'd0,  7'd127, 3'd0, 3'd6, 8'd3},
    {1'b0, 1'b1, 5'd9,  7'd2,   3'd6, 3'd3, 8'd40},
    {1'b1, 1'b0, 5'd7,  7'd1,   3'd3, 3'd2, 8'd1}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_en = 1'b0, arm_set = 1'b0, trig_mode = 1'b0, trig_edge = 1'b0, man_trig = 1'b0;
  logic [4:0]  trig_sel = '0;
  logic [6:0]  dly_cnt = '0;
  logic [2:0]  dly_unit = '0, rate_code = '0;
  logic [31:0] trig_bus = '0;
  logic [63:0] smp_data = '0;
  logic        mem_we, busy, done;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [31:0] status;

  int checks = 0, failures = 0;
  int cyc = 0, wr_n = 0, wr_bad = 0, done_cnt = 0;

  lac_capture #(.ADDR_W(AW), .CLK_MHZ(MHZ)) u0 (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .arm_set(arm_set), .trig_mode(trig_mode),
    .trig_edge(trig_edge), .trig_sel(trig_sel), .man_trig(man_trig), .dly_cnt(dly_cnt),
    .dly_unit(dly_unit), .rate_code(rate_code), .trig_bus(trig_bus), .smp_data(smp_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy),
    .done(done), .status(status)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) smp_data <= {32'hC0DE0000, cyc};

  // write monitor: sequential addresses, data sampled at the write edge (R3)
  always @(negedge clk) begin
    if (mem_we) begin
      if (mem_addr != AW'(wr_n % DEP) || mem_wdata != {32'hC0DE0000, cyc - 1}) wr_bad++;
      wr_n++;
    end
    if (done) done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input int i);
    logic [27:0] v;
    int p, q, k, t, d, n, x, last, nsave;
    logic lvl;
    logic [31:0] exp_st;
    v = VEC[i];
    @(negedge clk);
    trig_mode = v[27]; trig_edge = v[26]; trig_sel = v[25:21];
    dly_cnt = v[20:14]; dly_unit = v[13:11]; rate_code = v[10:8];
    lvl = v[26] && !v[27];
    trig_bus = lvl ? '1 : '0;
    man_trig = 1'b0;
    repeat (2) @(negedge clk);
    arm_set = 1'b1; p = cyc; wr_n = 0; wr_bad = 0;
    @(negedge clk);
    arm_set = 1'b0;
    chk(busy == 1'b1, "R2 busy after arm", busy, 1);
    trig_bus = trig_bus ^ ~(32'd1 << v[25:21]);   // R4: other bits toggle
    repeat (v[7:0]) @(negedge clk);
    if (v[27]) man_trig = 1'b1;                  // R6
    else trig_bus[v[25:21]] = ~trig_bus[v[25:21]]; // R5
    q = cyc;
    k = 0;
    do begin @(negedge clk); k++; end while (!done && k < 20000);
    t = int'(v[20:14]) << v[13:11];
    d = (v[10:8] == 3'd7) ? 1 : (2 << v[10:8]);
    x = q + 2 + t * MHZ;
    n = 0;
    for (int e = p + 2; e < x; e += d) n++;
    last = (n - 1) % DEP;
    exp_st = {(n >= DEP), 15'(last), 16'h0};
    chk(k == t * MHZ + 2, "R7 done latency", k, t * MHZ + 2);
    chk(busy == 1'b0, "R8 busy clears with done", busy, 0);
    chk(status == exp_st, "R9 status", status, exp_st);
    chk(wr_n == n, "R3 write count", wr_n, n);
    chk(wr_bad == 0, "R3 address and data", wr_bad, 0);
    @(negedge clk);
    chk(done == 1'b0, "R7 one-cycle done", done, 0);
    nsave = wr_n;
    repeat (6) @(negedge clk);
    chk(wr_n == nsave, "R8 no writes after done", wr_n, nsave);
    man_trig = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] st_save;
    int dc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && mem_we == 0, "R1 reset outputs", {busy, done, mem_we}, 0);
    chk(status == 0, "R1 reset status", status, 0);

    // R2: arm ignored while disabled
    arm_set = 1'b1; wr_n = 0;
    @(negedge clk); arm_set = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && wr_n == 0, "R2 arm ignored when disabled", busy, 0);

    cfg_en = 1'b1;
    for (int i = 0; i < NV; i++) run_vec(i);

    // R4/R5: idle edge ignored, wrong polarity ignored; R10 abort
    trig_mode = 1'b0; trig_edge = 1'b0; trig_sel = 5'd5; rate_code = 3'd7;
    dly_cnt = 7'd0; dly_unit = 3'd0; trig_bus = '0;
    @(negedge clk); trig_bus[5] = 1'b1;
    repeat (3) @(negedge clk);
    st_save = status; dc = done_cnt;
    arm_set = 1'b1;
    @(negedge clk); arm_set = 1'b0;
    repeat (4) @(negedge clk);
    trig_bus[5] = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy == 1'b1 && done_cnt == dc, "R4 R5 no trigger from idle edge or wrong polarity", busy, 1);
    cfg_en = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R10 abort clears busy", busy, 0);
    chk(done_cnt == dc, "R10 no done on abort", done_cnt, dc);
    chk(status == st_save, "R10 status unchanged", status, st_save);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule